// File: doc/BRIEF.md
# Two-Channel Memory-to-Memory DMA Engine

This block moves blocks of bytes from one place in a 24-bit memory space to another without processor help. It has two independent channels. Each channel has a programmed source start address, a destination start address, a 16-bit byte count and an 8-bit mode byte. Software programs these through a byte-wide indexed port. A write with the select line low sets a 7-bit pointer. A write with the select line high stores a byte at the pointed register and then moves the pointer up by one, so a channel can be loaded with one pointer write followed by a stream of data writes.

Starting a channel copies its programmed values into working counters. The engine then requests the bus and, once granted, moves one byte per transfer cycle. A transfer cycle is a read from the working source address, then a write of that byte to the working destination address. Each access waits for the bus ready signal. The addresses are full 24-bit counters, so a block crosses 64 KB boundaries with no wrap. Before every byte the engine picks the highest-numbered busy channel, so channel 1 overtakes channel 0 at the next byte boundary.

The controller has five states. In IDLE the bus is not requested; any busy channel moves it to WAIT_GNT. WAIT_GNT holds the request until the grant arrives, then goes to PICK. In PICK, a busy channel selects the winner and goes to READ; with no channel busy the engine returns to IDLE. READ goes to WRITE when ready is seen and captures the read byte. WRITE goes back to PICK when ready is seen and advances the chosen channel.

Top module: `dma2ch_engine`

## Requirements
- R1: Channel c has its register window at index 20h + 10h·c. Source address bytes sit at offsets 0, 1, 2 (low to high). Destination bytes sit at offsets 4, 5, 6. Count low and high sit at 8 and 9, and the mode byte at 0Ah. Each data write advances the pointer by one. Data reads return the programmed value. A pointer read (select low) returns the pointer with bit 7 at zero.
- R2: The mode byte uses bit 0 as start (write 1), bit 1 as source hold and bit 2 as destination hold. On read, bit 0 is the busy flag and bit 7 is the done flag.
- R3: Each byte is read from the working source address and then written, unchanged, to the working destination address. A read or write strobe stays asserted with a stable address (and stable write data) until bus_rdy is seen high. Read and write are never asserted together.
- R4: With the hold bit at 0, an address steps by +1 after each byte as a 24-bit counter, with a carry from bit 15 into bits 23:16.
- R5: With the hold bit at 1, that address stays at its start value for the whole block.
- R6: A channel moves exactly count bytes. A count of 0 moves 65536 bytes.
- R7: After the last byte is written, busy clears and done sets. A new start clears done.
- R8: When both channels are busy, channel 1 wins every byte boundary. Channel 0 completes at most the one byte already in flight.
- R9: A start written while the channel is busy has no effect on that channel's transfer.
- R10: The programmed start registers keep their values during and after a transfer.
- R11: bus_req is low after reset and high while a channel is busy. Strobes appear only while bus_gnt is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register port write strobe |
| cfg_sel | input | 1 | 0 = pointer, 1 = pointed data register |
| cfg_wdata | input | 8 | Register port write data |
| cfg_rdata | output | 8 | Pointer or pointed register, by cfg_sel |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_addr | output | 24 | Access address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data |
| bus_rdy | input | 1 | Access complete |
| chan_busy | output | 2 | Per-channel busy |
| chan_done | output | 2 | Per-channel done |

## Verification
The bench runs blocks that cross a 64 KB boundary on both addresses. A design with 16-bit address counters would write to the wrong high byte and fail the scoreboard compare. It runs source-hold and destination-hold blocks under random ready stalls. A design that dropped the hold or sampled read data before ready would emit wrong addresses or data. It starts channel 1 while channel 0 is mid-block. A design with inverted or per-block priority lets channel 0 keep writing and is caught. It also re-issues start on a busy channel, which would otherwise produce extra writes, and starts a zero-count block, which a naive design would finish at once or never start.

// File: rtl/dma_pkg.sv
package dma_pkg;
    localparam int ADDR_W  = 24;
    localparam int DATA_W  = 8;
    localparam int CNT_W   = 16;
    localparam int PTR_W   = 7;
    localparam int OFS_W   = 4;

    // register offsets inside a channel window
    localparam logic [OFS_W-1:0] OFS_SRC0 = 4'h0;
    localparam logic [OFS_W-1:0] OFS_SRC1 = 4'h1;
    localparam logic [OFS_W-1:0] OFS_SRC2 = 4'h2;
    localparam logic [OFS_W-1:0] OFS_DST0 = 4'h4;
    localparam logic [OFS_W-1:0] OFS_DST1 = 4'h5;
    localparam logic [OFS_W-1:0] OFS_DST2 = 4'h6;
    localparam logic [OFS_W-1:0] OFS_CNT0 = 4'h8;
    localparam logic [OFS_W-1:0] OFS_CNT1 = 4'h9;
    localparam logic [OFS_W-1:0] OFS_MODE = 4'hA;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  cnt;
        logic [6:1]        mode;
    } chan_regs_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_GNT,
        ST_PICK,
        ST_READ,
        ST_WRITE
    } dma_state_e;
endpackage

// File: rtl/dma_arbiter.sv
module dma_arbiter #(
    parameter int NCH  = 2,
    parameter int CH_W = 1
) (
    input  logic [NCH-1:0]  req,
    output logic            any,
    output logic [CH_W-1:0] win
);
    // fixed priority: the highest-numbered requester wins
    always_comb begin
        win = '0;
        for (int i = 0; i < NCH; i++) begin
            if (req[i]) win = CH_W'(i);
        end
    end

    assign any = |req;
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
    import dma_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int BASE   = 32,
    parameter int STRIDE = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr,
    input  logic                   sel,
    input  logic [DATA_W-1:0]      wdata,
    output logic [DATA_W-1:0]      rdata,
    input  logic [NCH-1:0]         busy,
    input  logic [NCH-1:0]         done,
    output logic [ADDR_W-1:0]      src   [NCH],
    output logic [ADDR_W-1:0]      dst   [NCH],
    output logic [CNT_W-1:0]       cnt   [NCH],
    output logic [NCH-1:0]         src_hold,
    output logic [NCH-1:0]         dst_hold,
    output logic [NCH-1:0]         start
);
    logic [PTR_W-1:0]  ptr_q;
    logic [DATA_W-1:0] rd_ch [NCH];
    logic              data_wr;

    assign data_wr = wr && sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (wr && !sel) begin
            ptr_q <= wdata[PTR_W-1:0];
        end else if (data_wr) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        localparam logic [PTR_W-1:0] CBASE = PTR_W'(BASE + c * STRIDE);
        chan_regs_t       regs_q;
        logic             hit;
        logic [OFS_W-1:0] ofs;

        assign hit = (ptr_q[PTR_W-1:OFS_W] == CBASE[PTR_W-1:OFS_W]);
        assign ofs = ptr_q[OFS_W-1:0];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q <= '0;
            end else if (data_wr && hit) begin
                unique case (ofs)
                    OFS_SRC0: regs_q.src[7:0]   <= wdata;
                    OFS_SRC1: regs_q.src[15:8]  <= wdata;
                    OFS_SRC2: regs_q.src[23:16] <= wdata;
                    OFS_DST0: regs_q.dst[7:0]   <= wdata;
                    OFS_DST1: regs_q.dst[15:8]  <= wdata;
                    OFS_DST2: regs_q.dst[23:16] <= wdata;
                    OFS_CNT0: regs_q.cnt[7:0]   <= wdata;
                    OFS_CNT1: regs_q.cnt[15:8]  <= wdata;
                    OFS_MODE: regs_q.mode       <= wdata[6:1];
                    default:  regs_q            <= regs_q;
                endcase
            end
        end

        // a start request is accepted only by an idle channel
        assign start[c] = data_wr && hit && (ofs == OFS_MODE) && wdata[0] && !busy[c];

        assign src[c]      = regs_q.src;
        assign dst[c]      = regs_q.dst;
        assign cnt[c]      = regs_q.cnt;
        assign src_hold[c] = regs_q.mode[1];
        assign dst_hold[c] = regs_q.mode[2];

        always_comb begin
            rd_ch[c] = '0;
            if (hit) begin
                unique case (ofs)
                    OFS_SRC0: rd_ch[c] = regs_q.src[7:0];
                    OFS_SRC1: rd_ch[c] = regs_q.src[15:8];
                    OFS_SRC2: rd_ch[c] = regs_q.src[23:16];
                    OFS_DST0: rd_ch[c] = regs_q.dst[7:0];
                    OFS_DST1: rd_ch[c] = regs_q.dst[15:8];
                    OFS_DST2: rd_ch[c] = regs_q.dst[23:16];
                    OFS_CNT0: rd_ch[c] = regs_q.cnt[7:0];
                    OFS_CNT1: rd_ch[c] = regs_q.cnt[15:8];
                    OFS_MODE: rd_ch[c] = {done[c], regs_q.mode, busy[c]};
                    default:  rd_ch[c] = '0;
                endcase
            end
        end
    end

    always_comb begin
        if (sel) begin
            rdata = '0;
            for (int i = 0; i < NCH; i++) rdata = rdata | rd_ch[i];
        end else begin
            rdata = DATA_W'(ptr_q);
        end
    end
endmodule

// File: rtl/dma_chan_ctx.sv
module dma_chan_ctx
    import dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] ld_src,
    input  logic [ADDR_W-1:0] ld_dst,
    input  logic [CNT_W-1:0]  ld_cnt,
    input  logic              ld_src_hold,
    input  logic              ld_dst_hold,
    input  logic              step,
    output logic [ADDR_W-1:0] wsrc,
    output logic [ADDR_W-1:0] wdst,
    output logic              busy,
    output logic              done
);
    logic [CNT_W-1:0] wcnt_q;
    logic             src_hold_q;
    logic             dst_hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wsrc       <= '0;
            wdst       <= '0;
            wcnt_q     <= '0;
            src_hold_q <= 1'b0;
            dst_hold_q <= 1'b0;
            busy       <= 1'b0;
            done       <= 1'b0;
        end else if (start) begin
            wsrc       <= ld_src;
            wdst       <= ld_dst;
            wcnt_q     <= ld_cnt;
            src_hold_q <= ld_src_hold;
            dst_hold_q <= ld_dst_hold;
            busy       <= 1'b1;
            done       <= 1'b0;
        end else if (step && busy) begin
            if (!src_hold_q) wsrc <= wsrc + 1'b1;
            if (!dst_hold_q) wdst <= wdst + 1'b1;
            // a zero count wraps to all ones, giving a full 2^CNT_W block
            wcnt_q <= wcnt_q - 1'b1;
            if (wcnt_q == CNT_W'(1)) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end

    // R7
    done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R5
    src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && busy && src_hold_q && !start) |=> $stable(wsrc));
endmodule

// File: rtl/dma2ch_engine.sv
module dma2ch_engine
    import dma_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int BASE   = 32,
    parameter int STRIDE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [23:0]       bus_addr,
    output logic [7:0]        bus_wdata,
    input  logic [7:0]        bus_rdata,
    input  logic              bus_rdy,
    output logic [NCH-1:0]    chan_busy,
    output logic [NCH-1:0]    chan_done
);
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    dma_state_e        state_q, state_d;
    logic [CH_W-1:0]   cur_q;
    logic [CH_W-1:0]   win;
    logic              any_busy;
    logic [DATA_W-1:0] data_q;

    logic [ADDR_W-1:0] cfg_src [NCH];
    logic [ADDR_W-1:0] cfg_dst [NCH];
    logic [CNT_W-1:0]  cfg_cnt [NCH];
    logic [NCH-1:0]    cfg_src_hold;
    logic [NCH-1:0]    cfg_dst_hold;
    logic [NCH-1:0]    start_p;
    logic [NCH-1:0]    step;
    logic [ADDR_W-1:0] wsrc [NCH];
    logic [ADDR_W-1:0] wdst [NCH];

    dma_regfile #(
        .NCH    (NCH),
        .BASE   (BASE),
        .STRIDE (STRIDE)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cfg_wr),
        .sel      (cfg_sel),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .busy     (chan_busy),
        .done     (chan_done),
        .src      (cfg_src),
        .dst      (cfg_dst),
        .cnt      (cfg_cnt),
        .src_hold (cfg_src_hold),
        .dst_hold (cfg_dst_hold),
        .start    (start_p)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ctx
        assign step[c] = (state_q == ST_WRITE) && bus_rdy && (cur_q == CH_W'(c));

        dma_chan_ctx u_ctx (
            .clk         (clk),
            .rst_n       (rst_n),
            .start       (start_p[c]),
            .ld_src      (cfg_src[c]),
            .ld_dst      (cfg_dst[c]),
            .ld_cnt      (cfg_cnt[c]),
            .ld_src_hold (cfg_src_hold[c]),
            .ld_dst_hold (cfg_dst_hold[c]),
            .step        (step[c]),
            .wsrc        (wsrc[c]),
            .wdst        (wdst[c]),
            .busy        (chan_busy[c]),
            .done        (chan_done[c])
        );
    end

    dma_arbiter #(
        .NCH  (NCH),
        .CH_W (CH_W)
    ) u_arb (
        .req (chan_busy),
        .any (any_busy),
        .win (win)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_PICK && any_busy) cur_q  <= win;
            if (state_q == ST_READ && bus_rdy)  data_q <= bus_rdata;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (any_busy) state_d = ST_WAIT_GNT;
            ST_WAIT_GNT: if (bus_gnt)  state_d = ST_PICK;
            ST_PICK:     state_d = any_busy ? ST_READ : ST_IDLE;
            ST_READ:     if (bus_rdy)  state_d = ST_WRITE;
            ST_WRITE:    if (bus_rdy)  state_d = ST_PICK;
            default:     state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bus_req   = (state_q != ST_IDLE);
        bus_rd    = (state_q == ST_READ);
        bus_wr    = (state_q == ST_WRITE);
        bus_addr  = (state_q == ST_READ) ? wsrc[cur_q] : wdst[cur_q];
        bus_wdata = data_q;
    end

    // R3
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R3
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_rdy) |=> (bus_rd && $stable(bus_addr)));

    // R3
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rdy) |=> (bus_wr && $stable(bus_addr) && $stable(bus_wdata)));

    // R11
    strobe_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> bus_gnt);

    // R11
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|chan_busy) && state_q == ST_IDLE) |=> bus_req);

    // R8
    prio_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PICK && chan_busy[NCH-1]) |=> (cur_q == CH_W'(NCH-1)));
endmodule

// File: tb/dma2ch_engine_bench.sv
`timescale 1ns/1ps
module dma2ch_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        bus_req;
    logic        bus_gnt = 1'b0;
    logic        bus_rd;
    logic        bus_wr;
    logic [23:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        bus_rdy = 1'b1;
    logic [1:0]  chan_busy;
    logic [1:0]  chan_done;

    int          n_chk = 0;
    int          n_fail = 0;
    logic [31:0] q0[$];
    logic [31:0] q1[$];
    int          zero_writes = 0;
    int          prio_ovl = 0;
    bit          stall_en = 1'b0;
    logic [7:0]  lfsr = 8'h01;

    always #4 clk = ~clk;

    dma2ch_engine u_dma2ch_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .bus_req   (bus_req),
        .bus_gnt   (bus_gnt),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_rdy   (bus_rdy),
        .chan_busy (chan_busy),
        .chan_done (chan_done)
    );

    function automatic logic [7:0] mem_byte(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
    endfunction

    assign bus_rdata = mem_byte(bus_addr);

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // monitor: bus model and scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if ((bus_rd || bus_wr) && !bus_gnt)
                check(1'b0, "R11", "strobe without grant", 1, 0);
            if (bus_wr && bus_rdy) begin
                logic [31:0] exp_item;
                unique case (bus_addr[23:20])
                    4'h1: begin
                        if (chan_busy[1]) begin
                            prio_ovl++;
                            if (prio_ovl > 1)
                                check(1'b0, "R8", "channel 0 write while channel 1 busy", prio_ovl, 1);
                        end
                        if (q0.size() == 0) begin
                            check(1'b0, "R9", "unexpected channel 0 write", bus_addr, 0);
                        end else begin
                            exp_item = q0.pop_front();
                            check({bus_addr, bus_wdata} == exp_item, "R3",
                                  "channel 0 write addr/data", {bus_addr, bus_wdata}, exp_item);
                        end
                    end
                    4'h2: begin
                        if (q1.size() == 0) begin
                            check(1'b0, "R9", "unexpected channel 1 write", bus_addr, 0);
                        end else begin
                            exp_item = q1.pop_front();
                            check({bus_addr, bus_wdata} == exp_item, "R3",
                                  "channel 1 write addr/data", {bus_addr, bus_wdata}, exp_item);
                        end
                    end
                    4'h3: zero_writes++;
                    default: check(1'b0, "R3", "write outside regions", bus_addr, 0);
                endcase
            end
            if (!chan_busy[1]) prio_ovl = 0;
        end
        bus_gnt <= bus_req;
        bus_rdy <= stall_en ? (lfsr[0] | lfsr[1]) : 1'b1;
        lfsr    <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end

    task automatic port_write(input logic sel, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_sel = sel;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic read_reg(input logic [7:0] idx, output logic [7:0] v);
        port_write(1'b0, idx);
        cfg_sel = 1'b1;
        #1;
        v = cfg_rdata;
    endtask

    task automatic prog(input int ch, input logic [23:0] src, input logic [23:0] dst,
                        input logic [15:0] cnt, input logic [7:0] mode);
        port_write(1'b0, 8'h20 + 8'(ch * 16));
        port_write(1'b1, src[7:0]);
        port_write(1'b1, src[15:8]);
        port_write(1'b1, src[23:16]);
        port_write(1'b1, 8'h00);
        port_write(1'b1, dst[7:0]);
        port_write(1'b1, dst[15:8]);
        port_write(1'b1, dst[23:16]);
        port_write(1'b1, 8'h00);
        port_write(1'b1, cnt[7:0]);
        port_write(1'b1, cnt[15:8]);
        port_write(1'b1, mode & 8'hFE);
    endtask

    // driver: push the expected writes into the scoreboard
    task automatic expect_block(input int ch, input logic [23:0] src, input logic [23:0] dst,
                                input int cnt, input logic [7:0] mode);
        for (int i = 0; i < cnt; i++) begin
            logic [23:0] s = mode[1] ? src : src + 24'(i);
            logic [23:0] d = mode[2] ? dst : dst + 24'(i);
            if (ch == 0) q0.push_back({d, mem_byte(s)});
            else         q1.push_back({d, mem_byte(s)});
        end
    endtask

    task automatic start_ch(input int ch, input logic [7:0] mode);
        port_write(1'b0, 8'h2A + 8'(ch * 16));
        port_write(1'b1, mode | 8'h01);
    endtask

    task automatic wait_idle(input int ch);
        while (chan_busy[ch]) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "ALL", "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check(bus_req == 1'b0, "R11", "bus_req after reset", bus_req, 0);
        check(chan_busy == 2'b00, "R2", "busy after reset", chan_busy, 0);
        check(chan_done == 2'b00, "R7", "done after reset", chan_done, 0);
        check(cfg_rdata == 8'h00, "R1", "pointer after reset", cfg_rdata, 0);

        // R1 register map and pointer auto-increment
        prog(0, 24'h00FFFE, 24'h10FFFC, 16'd6, 8'h00);
        cfg_sel = 1'b0; #1;
        check(cfg_rdata == 8'h2B, "R1", "pointer after 11 data writes", cfg_rdata, 8'h2B);
        read_reg(8'h22, v); check(v == 8'h00, "R1", "src high byte", v, 8'h00);
        read_reg(8'h21, v); check(v == 8'hFF, "R1", "src mid byte", v, 8'hFF);
        read_reg(8'h26, v); check(v == 8'h10, "R1", "dst high byte", v, 8'h10);
        read_reg(8'h28, v); check(v == 8'h06, "R1", "count low byte", v, 8'h06);

        // R4 64 KB crossing on both addresses, R6 exact count, R7 done
        expect_block(0, 24'h00FFFE, 24'h10FFFC, 6, 8'h00);
        start_ch(0, 8'h00);
        check(chan_busy[0] == 1'b1, "R2", "busy after start", chan_busy[0], 1);
        read_reg(8'h2A, v); check(v[0] == 1'b1, "R2", "mode busy bit", v[0], 1);
        wait_idle(0);
        @(negedge clk);
        check(chan_done[0] == 1'b1, "R7", "done after block", chan_done[0], 1);
        check(q0.size() == 0, "R6", "channel 0 writes outstanding", q0.size(), 0);
        read_reg(8'h2A, v); check(v == 8'h80, "R7", "mode readback done/idle", v, 8'h80);

        // R10 programmed values unchanged
        read_reg(8'h20, v); check(v == 8'hFE, "R10", "src low kept", v, 8'hFE);
        read_reg(8'h24, v); check(v == 8'hFC, "R10", "dst low kept", v, 8'hFC);
        read_reg(8'h28, v); check(v == 8'h06, "R10", "count kept", v, 8'h06);

        // R5 hold modes under stalls
        stall_en = 1'b1;
        prog(1, 24'h012345, 24'h200100, 16'd4, 8'h02);
        expect_block(1, 24'h012345, 24'h200100, 4, 8'h02);
        start_ch(1, 8'h02);
        wait_idle(1);
        @(negedge clk);
        check(q1.size() == 0, "R5", "source hold block complete", q1.size(), 0);
        prog(1, 24'h0000F0, 24'h200200, 16'd3, 8'h04);
        expect_block(1, 24'h0000F0, 24'h200200, 3, 8'h04);
        start_ch(1, 8'h04);
        wait_idle(1);
        @(negedge clk);
        check(q1.size() == 0, "R5", "destination hold block complete", q1.size(), 0);

        // R8 channel 1 overtakes channel 0
        prog(0, 24'h003000, 24'h101000, 16'd12, 8'h00);
        expect_block(0, 24'h003000, 24'h101000, 12, 8'h00);
        prog(1, 24'h004000, 24'h202000, 16'd4, 8'h00);
        expect_block(1, 24'h004000, 24'h202000, 4, 8'h00);
        start_ch(0, 8'h00);
        while (q0.size() > 10) @(negedge clk);
        start_ch(1, 8'h00);
        wait_idle(1);
        check(chan_busy[0] == 1'b1, "R8", "channel 0 still busy when channel 1 ends", chan_busy[0], 1);
        wait_idle(0);
        @(negedge clk);
        check(q0.size() == 0 && q1.size() == 0, "R8", "both blocks complete",
              q0.size() + q1.size(), 0);

        // R9 start while busy is ignored; R7 start clears done
        prog(0, 24'h006000, 24'h105000, 16'd5, 8'h00);
        check(chan_done[0] == 1'b1, "R7", "done before restart", chan_done[0], 1);
        expect_block(0, 24'h006000, 24'h105000, 5, 8'h00);
        start_ch(0, 8'h00);
        check(chan_done[0] == 1'b0, "R7", "done cleared by start", chan_done[0], 0);
        start_ch(0, 8'h00);
        wait_idle(0);
        repeat (20) @(negedge clk);
        check(q0.size() == 0 && chan_busy[0] == 1'b0, "R9", "only programmed bytes moved",
              q0.size(), 0);

        // R6 zero count means a full 65536-byte block
        stall_en = 1'b0;
        prog(1, 24'h050000, 24'h300000, 16'd0, 8'h00);
        start_ch(1, 8'h00);
        while (zero_writes < 300) @(negedge clk);
        check(chan_busy[1] == 1'b1, "R6", "zero count still busy after 300 bytes", chan_busy[1], 1);
        check(chan_done[1] == 1'b0, "R6", "zero count not done", chan_done[1], 0);

        summary();
        $finish;
    end
endmodule